// File: doc/BRIEF.md
# Writeback Load/Store Micro-op Cracker

This block sits after instruction decode. It takes one memory instruction per handshake, and the instruction may ask for its base register to be updated. The block turns that instruction into an ordered series of one, two or three micro-ops. It issues them one per cycle on a valid/ready output. The order is chosen so that downstream stages never see a register hazard. A load into the program counter is redirected to a scratch register, and the move into the program counter is issued last. If a load would overwrite the index register that the base update still needs, the index is first saved to the scratch register.

Each micro-op leaves with its kind, its register numbers and its operand fields. Register numbers on the output are one bit wider than on the input, so that the scratch register (number 16 with the default parameters) sits outside the 16 architectural registers. An instruction-level "conditional-block advance" flag leaves only on the final micro-op. The block does not execute micro-ops or touch memory.

Top module: `wb_uop_cracker`

Encodings used below. Class: 0 single load, 1 dual load, 2 store, 3 exception return, 4 state save, 5 vector multi transfer, 6 vector single transfer. Kind: 0 memory access, 1 add-immediate, 2 subtract-immediate, 3 add-shifted-register, 4 subtract-shifted-register, 5 register move. Shift type 0 is logical left. Register 15 is the program counter, and register 16 is the scratch register.

States: `ST_IDLE` and `ST_EMIT`. `ST_IDLE` waits with `in_ready` high. The transition `accept` (in_valid while idle) captures the instruction and goes to `ST_EMIT` at step 0. The transition `advance` (out_ready on a non-final micro-op) increments the step. The transition `retire` (out_ready on the final micro-op) returns to `ST_IDLE`.

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `in_wb`=0, one micro-op of kind 0 is emitted, with `out_last`=1 and destination equal to `in_dst`.
- R3: With no hazard, a writeback instruction gives kind 0 first. The second micro-op is the base update, with destination and source A equal to the base, and it carries `out_last`=1.
- R4: For loads and stores, the base update is an add (kind 1 or 3) when `in_add`=1 and a subtract (kind 2 or 4) when `in_add`=0.
- R5: An immediate offset gives a base update that carries `in_imm`. A register offset gives a base update that carries the index register with `in_shamt` and `in_shtype`.
- R6: A single load with destination 15 gives three micro-ops in this order: kind 0 into register 16, then the base update, then kind 5 with destination 15, source A 16 and `out_last`=1.
- R7: A register-offset single load whose destination equals the index gives three micro-ops in this order: kind 5 with destination 16 and source A equal to the index, then kind 0, then the base update with source B 16 and `out_last`=1.
- R8: A register-offset dual load gives the R7 three-step sequence when either destination equals the index, and two micro-ops otherwise.
- R9: Stores, exception returns and state saves with writeback always give exactly two micro-ops. For the last two classes the update is kind 1 carrying `in_imm`, whatever `in_add` is.
- R10: For vector transfers, an index other than 13 or 15 gives kind 3 with that index, shift 0 and type 0. Otherwise the update is kind 1 with immediate `in_vcnt`×8 (multi) or `in_imm` (single).
- R11: `out_cond_adv` is 1 only on the micro-op with `out_last`=1, and only when `in_cond_adv` was 1.
- R12: `in_ready` stays 0 from accept until the final micro-op is taken. While `out_valid`=1 and `out_ready`=0, all outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block can take an instruction |
| in_cls | input | 3 | Instruction class code |
| in_dst | input | 4 | Destination register |
| in_dst2 | input | 4 | Second destination (dual load) |
| in_base | input | 4 | Base register |
| in_idx | input | 4 | Index register |
| in_add | input | 1 | 1 adds the offset, 0 subtracts it |
| in_reg_off | input | 1 | 1 register offset, 0 immediate offset |
| in_shamt | input | 5 | Index shift amount |
| in_shtype | input | 2 | Index shift type |
| in_wb | input | 1 | Base writeback requested |
| in_imm | input | 12 | Immediate offset or transfer size |
| in_vcnt | input | 4 | Vector register count |
| in_cond_adv | input | 1 | Conditional-block advance flag |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Downstream takes the micro-op |
| out_kind | output | 3 | Micro-op kind code |
| out_cls | output | 3 | Class of the parent instruction |
| out_dst | output | 5 | Destination register |
| out_dst2 | output | 5 | Second destination |
| out_src_a | output | 5 | First source register |
| out_src_b | output | 5 | Second source / index register |
| out_add | output | 1 | Add/subtract bit of the parent |
| out_imm | output | 12 | Immediate operand |
| out_shamt | output | 5 | Shift amount for source B |
| out_shtype | output | 2 | Shift type for source B |
| out_last | output | 1 | Final micro-op of the instruction |
| out_cond_adv | output | 1 | Conditional-block advance |

## Verification
The bench builds the block with its defaults: 16 architectural registers, a 12-bit immediate, a 5-bit shift amount and a 4-bit vector count. With these values the program counter is 15, the scratch register is 16 and the vector immediate-fallback index is 13, so every hazard path and both vector update forms can be reached with small register numbers. A 4-bit count also reaches a multi-transfer size of 24 without the 12-bit immediate saturating. The bench also stalls the output for several cycles in the middle of a three-step sequence, which exercises the hold and ready behaviour.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [2:0] {
        IC_LOAD       = 3'd0,
        IC_LOAD_PAIR  = 3'd1,
        IC_STORE      = 3'd2,
        IC_EXC_RET    = 3'd3,
        IC_STATE_SAVE = 3'd4,
        IC_VEC_MULTI  = 3'd5,
        IC_VEC_SINGLE = 3'd6
    } iclass_e;

    typedef enum logic [2:0] {
        UK_MEM     = 3'd0,
        UK_ADD_IMM = 3'd1,
        UK_SUB_IMM = 3'd2,
        UK_ADD_REG = 3'd3,
        UK_SUB_REG = 3'd4,
        UK_MOVE    = 3'd5
    } ukind_e;

    typedef enum logic [1:0] {
        SEQ_SINGLE,
        SEQ_PAIR,
        SEQ_PC_LAST,
        SEQ_IDX_COPY
    } seq_e;

    typedef enum logic [2:0] {
        PK_MEM,
        PK_MEM_TMP,
        PK_WB,
        PK_MOV_PC,
        PK_MOV_IDX
    } pick_e;

    typedef enum logic {
        ST_IDLE,
        ST_EMIT
    } state_e;

endpackage

// File: rtl/wbc_planner.sv
module wbc_planner
    import wbc_pkg::*;
#(
    parameter int ARCH_W = 4
) (
    input  logic [2:0]        cls,
    input  logic              wb,
    input  logic              reg_off,
    input  logic [ARCH_W-1:0] dst,
    input  logic [ARCH_W-1:0] dst2,
    input  logic [ARCH_W-1:0] idx,
    output seq_e              seq
);

    localparam logic [ARCH_W-1:0] PC_NUM = '1;

    always_comb begin
        seq = SEQ_PAIR;
        if (!wb) begin
            seq = SEQ_SINGLE;
        end else begin
            case (cls)
                IC_LOAD: begin
                    if (dst == PC_NUM)
                        seq = SEQ_PC_LAST;
                    else if (reg_off && (dst == idx))
                        seq = SEQ_IDX_COPY;
                end
                IC_LOAD_PAIR: begin
                    if (reg_off && ((dst == idx) || (dst2 == idx)))
                        seq = SEQ_IDX_COPY;
                end
                default: seq = SEQ_PAIR;
            endcase
        end
    end

endmodule

// File: rtl/wbc_wb_builder.sv
module wbc_wb_builder
    import wbc_pkg::*;
#(
    parameter int ARCH_W  = 4,
    parameter int IMM_W   = 12,
    parameter int SHAMT_W = 5,
    parameter int VCNT_W  = 4
) (
    input  logic [2:0]         cls,
    input  logic               add,
    input  logic               reg_off,
    input  logic [ARCH_W-1:0]  idx,
    input  logic [IMM_W-1:0]   imm,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [1:0]         shtype,
    input  logic [VCNT_W-1:0]  vcnt,
    input  logic               use_tmp,
    output ukind_e             kind,
    output logic [ARCH_W:0]    src_b,
    output logic [IMM_W-1:0]   imm_o,
    output logic [SHAMT_W-1:0] shamt_o,
    output logic [1:0]         shtype_o
);

    localparam logic [ARCH_W-1:0] PC_NUM  = '1;
    localparam logic [ARCH_W-1:0] SP_NUM  = PC_NUM - 2'd2;
    localparam logic [ARCH_W:0]   TMP_NUM = {1'b1, {ARCH_W{1'b0}}};

    logic [IMM_W-1:0] vec_size;
    logic             vec_by_reg;

    assign vec_size   = (cls == IC_VEC_MULTI) ? (IMM_W'(vcnt) << 3) : imm;
    assign vec_by_reg = (idx != PC_NUM) && (idx != SP_NUM);

    always_comb begin
        kind     = UK_ADD_IMM;
        src_b    = '0;
        imm_o    = '0;
        shamt_o  = '0;
        shtype_o = '0;
        case (cls)
            IC_EXC_RET, IC_STATE_SAVE: begin
                imm_o = imm;
            end
            IC_VEC_MULTI, IC_VEC_SINGLE: begin
                if (vec_by_reg) begin
                    kind  = UK_ADD_REG;
                    src_b = {1'b0, idx};
                end else begin
                    imm_o = vec_size;
                end
            end
            default: begin
                if (reg_off) begin
                    kind     = add ? UK_ADD_REG : UK_SUB_REG;
                    src_b    = use_tmp ? TMP_NUM : {1'b0, idx};
                    shamt_o  = shamt;
                    shtype_o = shtype;
                end else begin
                    kind  = add ? UK_ADD_IMM : UK_SUB_IMM;
                    imm_o = imm;
                end
            end
        endcase
    end

endmodule

// File: rtl/wbc_step_sel.sv
module wbc_step_sel
    import wbc_pkg::*;
#(
    parameter int ARCH_W  = 4,
    parameter int IMM_W   = 12,
    parameter int SHAMT_W = 5
) (
    input  seq_e               seq,
    input  logic [1:0]         step,
    input  logic [ARCH_W-1:0]  dst,
    input  logic [ARCH_W-1:0]  dst2,
    input  logic [ARCH_W-1:0]  base,
    input  logic [ARCH_W-1:0]  idx,
    input  logic               add,
    input  logic [IMM_W-1:0]   imm,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [1:0]         shtype,
    input  ukind_e             wb_kind,
    input  logic [ARCH_W:0]    wb_src_b,
    input  logic [IMM_W-1:0]   wb_imm,
    input  logic [SHAMT_W-1:0] wb_shamt,
    input  logic [1:0]         wb_shtype,
    output logic [2:0]         kind,
    output logic [ARCH_W:0]    o_dst,
    output logic [ARCH_W:0]    o_dst2,
    output logic [ARCH_W:0]    o_src_a,
    output logic [ARCH_W:0]    o_src_b,
    output logic               o_add,
    output logic [IMM_W-1:0]   o_imm,
    output logic [SHAMT_W-1:0] o_shamt,
    output logic [1:0]         o_shtype,
    output logic               last
);

    localparam logic [ARCH_W:0] PC_NUM  = {1'b0, {ARCH_W{1'b1}}};
    localparam logic [ARCH_W:0] TMP_NUM = {1'b1, {ARCH_W{1'b0}}};

    pick_e  pick;
    ukind_e k;

    always_comb begin
        pick = PK_MEM;
        last = 1'b0;
        unique case (seq)
            SEQ_SINGLE: last = 1'b1;
            SEQ_PAIR: begin
                if (step != 2'd0) begin
                    pick = PK_WB;
                    last = 1'b1;
                end
            end
            SEQ_PC_LAST: begin
                case (step)
                    2'd0:    pick = PK_MEM_TMP;
                    2'd1:    pick = PK_WB;
                    default: begin
                        pick = PK_MOV_PC;
                        last = 1'b1;
                    end
                endcase
            end
            SEQ_IDX_COPY: begin
                case (step)
                    2'd0:    pick = PK_MOV_IDX;
                    2'd1:    pick = PK_MEM;
                    default: begin
                        pick = PK_WB;
                        last = 1'b1;
                    end
                endcase
            end
        endcase
    end

    always_comb begin
        k        = UK_MEM;
        o_dst    = '0;
        o_dst2   = '0;
        o_src_a  = '0;
        o_src_b  = '0;
        o_add    = add;
        o_imm    = '0;
        o_shamt  = '0;
        o_shtype = '0;
        case (pick)
            PK_MEM, PK_MEM_TMP: begin
                k        = UK_MEM;
                o_dst    = (pick == PK_MEM_TMP) ? TMP_NUM : {1'b0, dst};
                o_dst2   = {1'b0, dst2};
                o_src_a  = {1'b0, base};
                o_src_b  = {1'b0, idx};
                o_imm    = imm;
                o_shamt  = shamt;
                o_shtype = shtype;
            end
            PK_WB: begin
                k        = wb_kind;
                o_dst    = {1'b0, base};
                o_src_a  = {1'b0, base};
                o_src_b  = wb_src_b;
                o_imm    = wb_imm;
                o_shamt  = wb_shamt;
                o_shtype = wb_shtype;
            end
            PK_MOV_PC: begin
                k       = UK_MOVE;
                o_dst   = PC_NUM;
                o_src_a = TMP_NUM;
            end
            default: begin
                k       = UK_MOVE;
                o_dst   = TMP_NUM;
                o_src_a = {1'b0, idx};
            end
        endcase
    end

    assign kind = k;

endmodule

// File: rtl/wb_uop_cracker.sv
module wb_uop_cracker
    import wbc_pkg::*;
#(
    parameter int NUM_ARCH_REGS = 16,
    parameter int IMM_W         = 12,
    parameter int SHAMT_W       = 5,
    parameter int VCNT_W        = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid,
    output logic                             in_ready,
    input  logic [2:0]                       in_cls,
    input  logic [$clog2(NUM_ARCH_REGS)-1:0] in_dst,
    input  logic [$clog2(NUM_ARCH_REGS)-1:0] in_dst2,
    input  logic [$clog2(NUM_ARCH_REGS)-1:0] in_base,
    input  logic [$clog2(NUM_ARCH_REGS)-1:0] in_idx,
    input  logic                             in_add,
    input  logic                             in_reg_off,
    input  logic [SHAMT_W-1:0]               in_shamt,
    input  logic [1:0]                       in_shtype,
    input  logic                             in_wb,
    input  logic [IMM_W-1:0]                 in_imm,
    input  logic [VCNT_W-1:0]                in_vcnt,
    input  logic                             in_cond_adv,
    output logic                             out_valid,
    input  logic                             out_ready,
    output logic [2:0]                       out_kind,
    output logic [2:0]                       out_cls,
    output logic [$clog2(NUM_ARCH_REGS):0]   out_dst,
    output logic [$clog2(NUM_ARCH_REGS):0]   out_dst2,
    output logic [$clog2(NUM_ARCH_REGS):0]   out_src_a,
    output logic [$clog2(NUM_ARCH_REGS):0]   out_src_b,
    output logic                             out_add,
    output logic [IMM_W-1:0]                 out_imm,
    output logic [SHAMT_W-1:0]               out_shamt,
    output logic [1:0]                       out_shtype,
    output logic                             out_last,
    output logic                             out_cond_adv
);

    localparam int ARCH_W = $clog2(NUM_ARCH_REGS);

    state_e state_q, state_d;
    logic [1:0] step_q, step_d;
    seq_e plan_seq, seq_q;

    logic [2:0]         h_cls;
    logic [ARCH_W-1:0]  h_dst, h_dst2, h_base, h_idx;
    logic               h_add, h_reg_off, h_cond;
    logic [SHAMT_W-1:0] h_shamt;
    logic [1:0]         h_shtype;
    logic [IMM_W-1:0]   h_imm;
    logic [VCNT_W-1:0]  h_vcnt;

    ukind_e             wb_kind;
    logic [ARCH_W:0]    wb_src_b;
    logic [IMM_W-1:0]   wb_imm;
    logic [SHAMT_W-1:0] wb_shamt;
    logic [1:0]         wb_shtype;
    logic               sel_last;

    wbc_planner #(.ARCH_W(ARCH_W)) u_plan (
        .cls     (in_cls),
        .wb      (in_wb),
        .reg_off (in_reg_off),
        .dst     (in_dst),
        .dst2    (in_dst2),
        .idx     (in_idx),
        .seq     (plan_seq)
    );

    wbc_wb_builder #(
        .ARCH_W(ARCH_W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W), .VCNT_W(VCNT_W)
    ) u_wb (
        .cls      (h_cls),
        .add      (h_add),
        .reg_off  (h_reg_off),
        .idx      (h_idx),
        .imm      (h_imm),
        .shamt    (h_shamt),
        .shtype   (h_shtype),
        .vcnt     (h_vcnt),
        .use_tmp  (seq_q == SEQ_IDX_COPY),
        .kind     (wb_kind),
        .src_b    (wb_src_b),
        .imm_o    (wb_imm),
        .shamt_o  (wb_shamt),
        .shtype_o (wb_shtype)
    );

    wbc_step_sel #(.ARCH_W(ARCH_W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)) u_sel (
        .seq       (seq_q),
        .step      (step_q),
        .dst       (h_dst),
        .dst2      (h_dst2),
        .base      (h_base),
        .idx       (h_idx),
        .add       (h_add),
        .imm       (h_imm),
        .shamt     (h_shamt),
        .shtype    (h_shtype),
        .wb_kind   (wb_kind),
        .wb_src_b  (wb_src_b),
        .wb_imm    (wb_imm),
        .wb_shamt  (wb_shamt),
        .wb_shtype (wb_shtype),
        .kind      (out_kind),
        .o_dst     (out_dst),
        .o_dst2    (out_dst2),
        .o_src_a   (out_src_a),
        .o_src_b   (out_src_b),
        .o_add     (out_add),
        .o_imm     (out_imm),
        .o_shamt   (out_shamt),
        .o_shtype  (out_shtype),
        .last      (sel_last)
    );

    // next-state: accept, advance, retire
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    state_d = ST_EMIT;
                    step_d  = 2'd0;
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    if (sel_last)
                        state_d = ST_IDLE;
                    else
                        step_d = step_q + 2'd1;
                end
            end
        endcase
    end

    // state register and instruction hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            step_q    <= 2'd0;
            seq_q     <= SEQ_SINGLE;
            h_cls     <= '0;
            h_dst     <= '0;
            h_dst2    <= '0;
            h_base    <= '0;
            h_idx     <= '0;
            h_add     <= 1'b0;
            h_reg_off <= 1'b0;
            h_cond    <= 1'b0;
            h_shamt   <= '0;
            h_shtype  <= '0;
            h_imm     <= '0;
            h_vcnt    <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            if (state_q == ST_IDLE && in_valid) begin
                seq_q     <= plan_seq;
                h_cls     <= in_cls;
                h_dst     <= in_dst;
                h_dst2    <= in_dst2;
                h_base    <= in_base;
                h_idx     <= in_idx;
                h_add     <= in_add;
                h_reg_off <= in_reg_off;
                h_cond    <= in_cond_adv;
                h_shamt   <= in_shamt;
                h_shtype  <= in_shtype;
                h_imm     <= in_imm;
                h_vcnt    <= in_vcnt;
            end
        end
    end

    // outputs
    always_comb begin
        in_ready     = (state_q == ST_IDLE);
        out_valid    = (state_q == ST_EMIT);
        out_cls      = h_cls;
        out_last     = sel_last;
        out_cond_adv = out_valid && sel_last && h_cond;
    end

endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
    parameter int NUM_ARCH_REGS = 16,
    parameter int IMM_W         = 12
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           in_ready,
    input logic                           out_valid,
    input logic                           out_ready,
    input logic [2:0]                     out_kind,
    input logic [$clog2(NUM_ARCH_REGS):0] out_dst,
    input logic [$clog2(NUM_ARCH_REGS):0] out_src_a,
    input logic [$clog2(NUM_ARCH_REGS):0] out_src_b,
    input logic [IMM_W-1:0]               out_imm,
    input logic                           out_last,
    input logic                           out_cond_adv
);

    localparam int RW = $clog2(NUM_ARCH_REGS) + 1;
    localparam logic [RW-1:0] PC_NUM  = RW'(NUM_ARCH_REGS - 1);
    localparam logic [RW-1:0] TMP_NUM = RW'(NUM_ARCH_REGS);

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_dst)
            && $stable(out_src_a) && $stable(out_src_b) && $stable(out_imm) && $stable(out_last))
        else $error("stall_hold_chk");

    // R12
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !(out_ready && out_last) |=> !in_ready)
        else $error("busy_ready_chk");

    // R12
    retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> in_ready && !out_valid)
        else $error("retire_chk");

    // R11
    cond_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_cond_adv |-> out_last)
        else $error("cond_last_chk");

    // R6
    pc_move_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == 3'd5 && out_dst == PC_NUM |-> out_last)
        else $error("pc_move_last_chk");

    // R6
    tmp_load_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == 3'd0 && out_dst == TMP_NUM |-> !out_last)
        else $error("tmp_load_mid_chk");

    // R7
    idx_copy_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == 3'd5 && out_dst == TMP_NUM |-> !out_last)
        else $error("idx_copy_first_chk");

endmodule

bind wb_uop_cracker wbc_checker #(.NUM_ARCH_REGS(NUM_ARCH_REGS), .IMM_W(IMM_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_kind     (out_kind),
    .out_dst      (out_dst),
    .out_src_a    (out_src_a),
    .out_src_b    (out_src_b),
    .out_imm      (out_imm),
    .out_last     (out_last),
    .out_cond_adv (out_cond_adv)
);

// File: tb/sim_wb_uop_cracker.sv
module sim_wb_uop_cracker;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_ready;
    logic [2:0]  in_cls = '0;
    logic [3:0]  in_dst = '0, in_dst2 = '0, in_base = '0, in_idx = '0;
    logic        in_add = 1'b0, in_reg_off = 1'b0, in_wb = 1'b0, in_cond_adv = 1'b0;
    logic [4:0]  in_shamt = '0;
    logic [1:0]  in_shtype = '0;
    logic [11:0] in_imm = '0;
    logic [3:0]  in_vcnt = '0;
    logic        out_valid, out_ready = 1'b1;
    logic [2:0]  out_kind, out_cls;
    logic [4:0]  out_dst, out_dst2, out_src_a, out_src_b;
    logic        out_add, out_last, out_cond_adv;
    logic [11:0] out_imm;
    logic [4:0]  out_shamt;
    logic [1:0]  out_shtype;

    wb_uop_cracker u0 (.*);

    typedef struct packed {
        logic [2:0]  cls;
        logic [3:0]  dst, dst2, base, idx;
        logic        add, roff;
        logic [11:0] imm;
        logic [3:0]  vcnt;
        logic        wb;
        logic [1:0]  len, wbp;
        logic [2:0]  k0, k1, k2;
        logic [4:0]  d0, d1, d2;
        logic [4:0]  wbb;
        logic [11:0] wbimm;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 4'd1, 4'd0, 4'd4, 4'd2, 1'b1, 1'b0, 12'd16, 4'd0, 1'b0, 2'd1, 2'd0, 3'd0, 3'd0, 3'd0, 5'd1, 5'd0, 5'd0, 5'd0, 12'd0},
        '{3'd0, 4'd1, 4'd0, 4'd4, 4'd2, 1'b1, 1'b0, 12'd16, 4'd0, 1'b1, 2'd2, 2'd1, 3'd0, 3'd1, 3'd0, 5'd1, 5'd4, 5'd0, 5'd0, 12'd16},
        '{3'd0, 4'd1, 4'd0, 4'd4, 4'd2, 1'b0, 1'b0, 12'd16, 4'd0, 1'b1, 2'd2, 2'd1, 3'd0, 3'd2, 3'd0, 5'd1, 5'd4, 5'd0, 5'd0, 12'd16},
        '{3'd0, 4'd1, 4'd0, 4'd4, 4'd2, 1'b1, 1'b1, 12'd0,  4'd0, 1'b1, 2'd2, 2'd1, 3'd0, 3'd3, 3'd0, 5'd1, 5'd4, 5'd0, 5'd2, 12'd0},
        '{3'd0, 4'd1, 4'd0, 4'd4, 4'd2, 1'b0, 1'b1, 12'd0,  4'd0, 1'b1, 2'd2, 2'd1, 3'd0, 3'd4, 3'd0, 5'd1, 5'd4, 5'd0, 5'd2, 12'd0},
        '{3'd0, 4'd15,4'd0, 4'd4, 4'd2, 1'b1, 1'b0, 12'd8,  4'd0, 1'b1, 2'd3, 2'd1, 3'd0, 3'd1, 3'd5, 5'd16,5'd4, 5'd15,5'd0, 12'd8},
        '{3'd0, 4'd2, 4'd0, 4'd4, 4'd2, 1'b1, 1'b1, 12'd0,  4'd0, 1'b1, 2'd3, 2'd2, 3'd5, 3'd0, 3'd3, 5'd16,5'd2, 5'd4, 5'd16,12'd0},
        '{3'd0, 4'd2, 4'd0, 4'd4, 4'd2, 1'b1, 1'b0, 12'd4,  4'd0, 1'b1, 2'd2, 2'd1, 3'd0, 3'd1, 3'd0, 5'd2, 5'd4, 5'd0, 5'd0, 12'd4},
        '{3'd1, 4'd6, 4'd7, 4'd4, 4'd7, 1'b1, 1'b1, 12'd0,  4'd0, 1'b1, 2'd3, 2'd2, 3'd5, 3'd0, 3'd3, 5'd16,5'd6, 5'd4, 5'd16,12'd0},
        '{3'd1, 4'd6, 4'd7, 4'd4, 4'd3, 1'b0, 1'b1, 12'd0,  4'd0, 1'b1, 2'd2, 2'd1, 3'd0, 3'd4, 3'd0, 5'd6, 5'd4, 5'd0, 5'd3, 12'd0},
        '{3'd2, 4'd2, 4'd0, 4'd4, 4'd2, 1'b1, 1'b1, 12'd0,  4'd0, 1'b1, 2'd2, 2'd1, 3'd0, 3'd3, 3'd0, 5'd2, 5'd4, 5'd0, 5'd2, 12'd0},
        '{3'd3, 4'd0, 4'd0, 4'd4, 4'd0, 1'b1, 1'b0, 12'hFF8,4'd0, 1'b1, 2'd2, 2'd1, 3'd0, 3'd1, 3'd0, 5'd0, 5'd4, 5'd0, 5'd0, 12'hFF8},
        '{3'd4, 4'd0, 4'd0, 4'd4, 4'd0, 1'b0, 1'b0, 12'd8,  4'd0, 1'b1, 2'd2, 2'd1, 3'd0, 3'd1, 3'd0, 5'd0, 5'd4, 5'd0, 5'd0, 12'd8},
        '{3'd5, 4'd0, 4'd0, 4'd4, 4'd5, 1'b1, 1'b0, 12'd0,  4'd3, 1'b1, 2'd2, 2'd1, 3'd0, 3'd3, 3'd0, 5'd0, 5'd4, 5'd0, 5'd5, 12'd0},
        '{3'd5, 4'd0, 4'd0, 4'd4, 4'd13,1'b1, 1'b0, 12'd0,  4'd3, 1'b1, 2'd2, 2'd1, 3'd0, 3'd1, 3'd0, 5'd0, 5'd4, 5'd0, 5'd0, 12'd24},
        '{3'd6, 4'd0, 4'd0, 4'd4, 4'd15,1'b1, 1'b0, 12'd4,  4'd0, 1'b1, 2'd2, 2'd1, 3'd0, 3'd1, 3'd0, 5'd0, 5'd4, 5'd0, 5'd0, 12'd4},
        '{3'd0, 4'd15,4'd0, 4'd4, 4'd15,1'b1, 1'b1, 12'd0,  4'd0, 1'b1, 2'd3, 2'd1, 3'd0, 3'd3, 3'd5, 5'd16,5'd4, 5'd15,5'd15,12'd0},
        '{3'd2, 4'd15,4'd0, 4'd4, 4'd2, 1'b1, 1'b0, 12'd4,  4'd0, 1'b1, 2'd2, 2'd1, 3'd0, 3'd1, 3'd0, 5'd15,5'd4, 5'd0, 5'd0, 12'd4}
    };
    localparam string TAGS [NV] = '{
        "R2", "R3", "R4", "R5", "R4", "R6", "R7", "R5", "R8",
        "R8", "R9", "R9", "R9", "R10", "R10", "R10", "R6", "R9"
    };

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // present the instruction; returns at the negedge where step 0 is visible
    task automatic present();
        @(negedge clk);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic load_vec(input vec_t v);
        in_cls = v.cls; in_dst = v.dst; in_dst2 = v.dst2; in_base = v.base;
        in_idx = v.idx; in_add = v.add; in_reg_off = v.roff; in_imm = v.imm;
        in_vcnt = v.vcnt; in_wb = v.wb; in_shamt = 5'd2; in_shtype = 2'd1;
        in_cond_adv = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 in_ready", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 in_ready after release", int'(in_ready), 1);

        for (int v = 0; v < NV; v++) begin
            load_vec(VECS[v]);
            present();
            for (int s = 0; s < int'(VECS[v].len); s++) begin
                int ek, ed;
                ek = (s == 0) ? int'(VECS[v].k0) : (s == 1) ? int'(VECS[v].k1) : int'(VECS[v].k2);
                ed = (s == 0) ? int'(VECS[v].d0) : (s == 1) ? int'(VECS[v].d1) : int'(VECS[v].d2);
                chk({TAGS[v], " valid"}, int'(out_valid), 1);
                chk({TAGS[v], " kind"}, int'(out_kind), ek);
                chk({TAGS[v], " dst"}, int'(out_dst), ed);
                chk({TAGS[v], " last"}, int'(out_last), (s == int'(VECS[v].len) - 1) ? 1 : 0);
                if (VECS[v].len > 2'd1 && s == int'(VECS[v].wbp)) begin
                    chk({TAGS[v], " update src_a"}, int'(out_src_a), int'(VECS[v].base));
                    chk({TAGS[v], " update src_b"}, int'(out_src_b), int'(VECS[v].wbb));
                    chk({TAGS[v], " update imm"}, int'(out_imm), int'(VECS[v].wbimm));
                end
                if (ek == 5 && ed == 15) chk("R6 move source", int'(out_src_a), 16);
                if (ek == 5 && ed == 16) chk("R7 copy source", int'(out_src_a), int'(VECS[v].idx));
                if (s < int'(VECS[v].len) - 1) begin
                    chk("R12 ready low mid sequence", int'(in_ready), 0);
                    @(negedge clk);
                end
            end
            @(negedge clk);
            chk("R12 ready after retire", int'(in_ready), 1);
            chk("R12 valid after retire", int'(out_valid), 0);
        end

        // R5 shift fields reach the register-offset update
        load_vec(VECS[3]);
        in_shamt = 5'd3; in_shtype = 2'd2;
        present();
        @(negedge clk);
        chk("R5 update shamt", int'(out_shamt), 3);
        chk("R5 update shtype", int'(out_shtype), 2);
        @(negedge clk);

        // R10 vector register update has zero shift
        load_vec(VECS[13]);
        present();
        @(negedge clk);
        chk("R10 vector shamt", int'(out_shamt), 0);
        chk("R10 vector shtype", int'(out_shtype), 0);
        @(negedge clk);

        // R11 conditional advance only on the final micro-op
        load_vec(VECS[1]);
        in_cond_adv = 1'b1;
        present();
        chk("R11 cond on first", int'(out_cond_adv), 0);
        @(negedge clk);
        chk("R11 cond on last", int'(out_cond_adv), 1);
        @(negedge clk);
        load_vec(VECS[0]);
        in_cond_adv = 1'b1;
        present();
        chk("R11 cond on uncracked", int'(out_cond_adv), 1);
        chk("R2 uncracked last", int'(out_last), 1);
        @(negedge clk);

        // R12 stall mid sequence
        load_vec(VECS[5]);
        out_ready = 1'b0;
        present();
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk("R12 stall valid", int'(out_valid), 1);
        chk("R12 stall kind", int'(out_kind), 0);
        chk("R12 stall dst", int'(out_dst), 16);
        chk("R12 stall ready", int'(in_ready), 0);
        out_ready = 1'b1;
        @(negedge clk);
        chk("R12 after stall kind", int'(out_kind), 1);
        @(negedge clk);
        chk("R6 after stall final", int'(out_kind), 5);
        chk("R6 after stall last", int'(out_last), 1);
        @(negedge clk);
        chk("R12 idle after stall", int'(in_ready), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R12 watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule